// File: doc/BRIEF.md
# 100BASE-TX Transmit Nibble to Code-Group Encoder

This block sits between a media-independent transmit nibble stream and the scrambler of a 100BASE-TX physical layer. On every rising edge of the 25 MHz transmit clock it samples the frame enable, the error flag and the 4-bit data nibble. It produces one 5-bit code-group in the cycle that follows.

Between frames the block sends the idle code-group without a break, so the far end keeps its clock recovery locked. When a frame starts, the block overwrites the first two preamble nibbles with the J and K start-delimiter groups. Each later nibble is translated through the 4B/5B data table. A nibble flagged with the error input is sent as the halt group instead. Once the enable drops, the T and R end-delimiter groups follow, and idle resumes after them.

The output is a stream that cannot be stalled. It has a valid strobe and no ready input, because the line clock cannot be held. The valid strobe stays high in every cycle after reset, and the consumer must accept every beat. The block likewise applies no back-pressure to its source: a nibble is consumed on every edge whether or not a frame is active.

Top module: `tx4b5b_enc`

## Requirements
- R1: While rst_n is low, grp_out is idle (11111) and grp_valid is low. From the first clock edge after rst_n goes high, grp_valid is high in every cycle. There is no ready input and no back-pressure.
- R2: While no frame is active and tx_en is sampled low, grp_out is idle (11111) one cycle after each edge.
- R3: At the first edge where tx_en is sampled high while no frame is active, the block emits J (11000) in place of that nibble.
- R4: At the edge after J, the block emits K (10001) in place of the second preamble nibble, whatever the values of txd and tx_er.
- R5: From the third enabled nibble on, each nibble maps to its data code-group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A data nibble sampled with tx_en and tx_er both high is replaced by halt (00100).
- R7: At the first edge where tx_en is sampled low after data, the block emits T (01101). On the next edge it emits R (00111), whatever the inputs are. After that it emits idle, unless a new frame starts.
- R8: The value of tx_er has no effect while tx_en is low outside a frame, on the J and K beats, or on the edge that ends a frame (that edge still gives T).
- R9: If tx_en falls on the K beat, the block still emits K, and then emits T and R on the following two edges.
- R10: If tx_en is high on the R beat, R is still emitted. J follows at the next edge where tx_en is high, and K at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag for the current nibble |
| txd | input | 4 | Transmit data nibble |
| grp_out | output | 5 | Encoded code-group, registered |
| grp_valid | output | 1 | High in every cycle after reset; there is no ready |

## Verification
Two functions can fall in the same cycle: the end of one frame and the start of the next. The bench raises tx_en again on the very edge where R is due, and holds it high. It then expects R, then J, then K, and then the mapped data, so a sequencer that lets the new frame cut off the delimiter is caught. A second overlap is the error flag arriving on the edge that ends a frame, or on a delimiter beat. In both cases the expected group stays T, J or K and never becomes halt.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [GRP_W-1:0] grp_t;

  localparam grp_t GRP_IDLE = 5'b11111;
  localparam grp_t GRP_J    = 5'b11000;
  localparam grp_t GRP_K    = 5'b10001;
  localparam grp_t GRP_T    = 5'b01101;
  localparam grp_t GRP_R    = 5'b00111;
  localparam grp_t GRP_HALT = 5'b00100;

  // Frame position held between edges
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_K,
    ST_DATA,
    ST_R
  } seq_st_e;

  // Which group the output register loads at this edge
  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_J,
    SEL_K,
    SEL_DATA,
    SEL_HALT,
    SEL_T,
    SEL_R
  } grp_sel_e;
endpackage

// File: rtl/tx4b5b_map.sv
module tx4b5b_map
  import tx4b5b_pkg::*;
(
  input  nib_t nib_in,
  output grp_t grp_o
);
  always_comb begin
    unique case (nib_in)
      4'h0: grp_o = 5'b11110;
      4'h1: grp_o = 5'b01001;
      4'h2: grp_o = 5'b10100;
      4'h3: grp_o = 5'b10101;
      4'h4: grp_o = 5'b01010;
      4'h5: grp_o = 5'b01011;
      4'h6: grp_o = 5'b01110;
      4'h7: grp_o = 5'b01111;
      4'h8: grp_o = 5'b10010;
      4'h9: grp_o = 5'b10011;
      4'hA: grp_o = 5'b10110;
      4'hB: grp_o = 5'b10111;
      4'hC: grp_o = 5'b11010;
      4'hD: grp_o = 5'b11011;
      4'hE: grp_o = 5'b11100;
      default: grp_o = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx4b5b_seq.sv
module tx4b5b_seq
  import tx4b5b_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_en,
  input  logic     tx_er,
  output grp_sel_e sel_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    sel_o = SEL_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_en) begin
          sel_o = SEL_J;      // R3 first preamble nibble overwritten
          st_d  = ST_K;
        end
      end
      ST_K: begin
        sel_o = SEL_K;        // R4, R9: K regardless of enable
        st_d  = ST_DATA;
      end
      ST_DATA: begin
        if (tx_en) begin
          sel_o = tx_er ? SEL_HALT : SEL_DATA;
        end else begin
          sel_o = SEL_T;      // R7 end delimiter wins over error
          st_d  = ST_R;
        end
      end
      default: begin
        sel_o = SEL_R;        // R10 R always completes
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/tx4b5b_enc.sv
module tx4b5b_enc
  import tx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [GRP_W-1:0] grp_out,
  output logic             grp_valid
);
  grp_sel_e sel;
  grp_t     data_grp;
  grp_t     grp_d;

  tx4b5b_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .tx_er (tx_er),
    .sel_o (sel)
  );

  tx4b5b_map u_map (
    .nib_in (txd),
    .grp_o  (data_grp)
  );

  always_comb begin
    unique case (sel)
      SEL_J:    grp_d = GRP_J;
      SEL_K:    grp_d = GRP_K;
      SEL_DATA: grp_d = data_grp;
      SEL_HALT: grp_d = GRP_HALT;
      SEL_T:    grp_d = GRP_T;
      SEL_R:    grp_d = GRP_R;
      default:  grp_d = GRP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_out   <= GRP_IDLE;
      grp_valid <= 1'b0;
    end else begin
      grp_out   <= grp_d;
      grp_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/tx4b5b_chk.sv
module tx4b5b_chk
  import tx4b5b_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_er,
  input logic [GRP_W-1:0] grp_out,
  input logic             grp_valid
);
  logic rest_q;
  logic data_q;
  assign rest_q = (grp_out == GRP_IDLE) || (grp_out == GRP_R);
  assign data_q = !(grp_out inside {GRP_IDLE, GRP_J, GRP_K, GRP_T, GRP_R});

  // R1
  valid_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> grp_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && rest_q && !tx_en) |=> (grp_out == GRP_IDLE));

  // R3
  start_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && rest_q && tx_en) |=> (grp_out == GRP_J));

  // R4
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_out == GRP_J) |=> (grp_out == GRP_K));

  // R6
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_out == GRP_K || data_q) && tx_en && tx_er) |=> (grp_out == GRP_HALT));

  // R7
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_out == GRP_T) |=> (grp_out == GRP_R));

  // R9
  k_end_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_out == GRP_K || data_q) && !tx_en) |=> (grp_out == GRP_T));
endmodule

bind tx4b5b_enc tx4b5b_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .tx_er     (tx_er),
  .grp_out   (grp_out),
  .grp_valid (grp_valid)
);

// File: tb/sim_tx4b5b_enc.sv
module sim_tx4b5b_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] grp_out;
  logic       grp_valid;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                         E_T = 5'b01101, E_R = 5'b00111, E_HALT = 5'b00100;

  tx4b5b_enc u0 (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
                 .txd(txd), .grp_out(grp_out), .grp_valid(grp_valid));

  always #5 clk = ~clk;

  function automatic logic [4:0] exp_data(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input logic [4:0] exp, input logic exp_v, input string req);
    checks++;
    if (grp_out !== exp || grp_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: got grp=%b valid=%b, expected grp=%b valid=%b",
               req, grp_out, grp_valid, exp, exp_v);
    end
  endtask

  // drive one nibble at the falling edge, check the group after the rising edge
  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic [4:0] exp, input string req);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d;
    @(posedge clk);
    #1;
    check(exp, 1'b1, req);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(E_IDLE, 1'b0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(E_IDLE, 1'b1, "R1 valid after reset");
  endtask

  task automatic test_idle;
    step(1'b0, 1'b0, 4'h5, E_IDLE, "R2 idle");
    step(1'b0, 1'b1, 4'hA, E_IDLE, "R8 tx_er ignored outside frame");
    step(1'b0, 1'b0, 4'hF, E_IDLE, "R2 idle");
  endtask

  task automatic test_all_nibbles;
    step(1'b1, 1'b0, 4'h5, E_J, "R3 J");
    step(1'b1, 1'b0, 4'h5, E_K, "R4 K");
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b0, 4'(i), exp_data(4'(i)), "R5 data map");
    step(1'b0, 1'b0, 4'h0, E_T, "R7 T");
    step(1'b1, 1'b1, 4'h3, E_R, "R7 R regardless of inputs");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R7 idle after R");
  endtask

  task automatic test_err;
    step(1'b1, 1'b1, 4'h5, E_J, "R8 tx_er ignored on J");
    step(1'b1, 1'b1, 4'h5, E_K, "R8 tx_er ignored on K");
    step(1'b1, 1'b0, 4'h9, exp_data(4'h9), "R5 data");
    step(1'b1, 1'b1, 4'h9, E_HALT, "R6 halt");
    step(1'b1, 1'b0, 4'hC, exp_data(4'hC), "R6 data after halt");
    step(1'b0, 1'b1, 4'h0, E_T, "R8 tx_er ignored at frame end");
    step(1'b0, 1'b0, 4'h0, E_R, "R7 R");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R7 idle");
  endtask

  task automatic test_short;
    step(1'b1, 1'b0, 4'h5, E_J, "R9 J");
    step(1'b0, 1'b0, 4'h5, E_K, "R9 K after early drop");
    step(1'b0, 1'b0, 4'h0, E_T, "R9 T");
    step(1'b0, 1'b0, 4'h0, E_R, "R9 R");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R9 idle");
  endtask

  task automatic test_back_to_back;
    step(1'b1, 1'b0, 4'h5, E_J, "R10 J");
    step(1'b1, 1'b0, 4'h5, E_K, "R10 K");
    step(1'b1, 1'b0, 4'h2, exp_data(4'h2), "R10 data");
    step(1'b0, 1'b0, 4'h0, E_T, "R10 T");
    step(1'b1, 1'b0, 4'h5, E_R, "R10 R kept on restart");
    step(1'b1, 1'b0, 4'h5, E_J, "R10 J after R");
    step(1'b1, 1'b0, 4'h5, E_K, "R10 K after R");
    step(1'b1, 1'b0, 4'hD, exp_data(4'hD), "R10 data");
    step(1'b0, 1'b0, 4'h0, E_T, "R10 T");
    step(1'b0, 1'b0, 4'h0, E_R, "R10 R");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R10 idle");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_idle();
    test_all_nibbles();
    test_err();
    test_short();
    test_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule